// File: doc/BRIEF.md
# Branch Target Cache

This block sits beside the instruction fetch path and remembers where previously taken branches went. On every cycle it is given the current fetch PC, splits it into an index and a tag, and compares that tag against the entry the index picks. When the entry is valid and the tags agree, the block reports a hit and returns the stored target address. This makes the destination of a taken branch available in the cycle of its fetch, before the instruction has been decoded.

The direction of the branch comes from a separate predictor and is an input here. The next fetch PC goes to the stored target only when the lookup hits and that input says taken. In every other case it steps sequentially by four bytes. When a branch resolves, the update port writes the entry if the branch was taken and leaves the entry alone if it was not. The default organisation is direct-mapped with 16 entries over a 32-bit PC.

Top module: `tgt_cache`

## Requirements
- R1: After the active-low reset, every entry is invalid: any fetch PC misses (hit_o = 0) and next_pc_o equals fetch_pc_i + 4.
- R2: A hit needs the indexed entry to be valid and its stored tag to equal fetch PC bits [31:6] (default parameters). A PC with the same index but a different tag misses.
- R3: PC bits [1:0] are ignored, and the index is PC bits [5:2]. PCs that differ only in bits [1:0] give the same lookup result.
- R4: On a hit, pred_tgt_o carries the stored target. On a miss, pred_tgt_o is zero.
- R5: next_pc_o is the stored target only when hit_o = 1 and pred_taken_i = 1. Otherwise it is fetch_pc_i + 4, taken modulo 2^32.
- R6: An update with upd_taken_i = 1 makes the indexed entry valid and stores its tag and target, replacing any earlier contents, including those of a branch with a different tag at the same index.
- R7: An update with upd_taken_i = 0 leaves the indexed entry unchanged.
- R8: When a write and a lookup address the same entry in one cycle, the lookup sees the old contents. The new contents are visible from the next cycle.
- R9: A write changes only the entry its index selects. The other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | PC being fetched this cycle |
| pred_taken_i | input | 1 | Predicted direction from the external predictor, 1 = taken |
| hit_o | output | 1 | Valid entry with a matching tag |
| pred_tgt_o | output | PC_W | Stored target on a hit, zero on a miss |
| next_pc_o | output | PC_W | Selected next fetch PC |
| upd_en_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_tgt_i | input | PC_W | Resolved target address |

## Verification
The checker watches the next-PC selection on every cycle: the sequential step on any miss, the stored target on a hit predicted taken, and a zero target output on a miss. It also checks that a taken update is seen as a hit with the written target in the next cycle whenever that same PC is fetched. Other behaviours depend on what the table holds over time, so only the bench's scenarios, checked against a behavioural model, can show them. These are the aliasing of tags on one index, the replacement of an entry by a different branch, an update marked not taken leaving the entry as it was, the same-cycle read of old contents, and the independence of the entries.

// File: rtl/tgt_cache_pkg.sv
package tgt_cache_pkg;
  localparam int unsigned BYTE_OFF_W = 2;
  localparam int unsigned SEQ_STEP   = 4;

  typedef enum logic {
    NPC_SEQ = 1'b0,
    NPC_TGT = 1'b1
  } npc_src_e;
endpackage

// File: rtl/tgt_cache_split.sv
module tgt_cache_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 2,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = PC_W - IDX_W - OFF_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [OFF_W-1:0] off_unused;

  assign off_unused = pc_i[OFF_W-1:0];
  assign idx_o      = pc_i[OFF_W +: IDX_W];
  assign tag_o      = pc_i[PC_W-1 -: TAG_W];
endmodule

// File: rtl/tgt_cache_store.sv
module tgt_cache_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 26,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [DEPTH-1:0] wr_sel;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign wr_sel[e] = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        valid_q[e] <= 1'b0;
      else if (wr_sel[e]) valid_q[e] <= 1'b1;
    end

    // payload needs no reset: qualified by valid_q
    always_ff @(posedge clk_i) begin
      if (wr_sel[e]) begin
        tag_q[e] <= wr_tag_i;
        tgt_q[e] <= wr_tgt_i;
      end
    end
  end

  // read is combinational from the registers, so a same-cycle write shows old data
  always_comb begin
    hit_o    = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    rd_tgt_o = hit_o ? tgt_q[rd_idx_i] : '0;
  end
endmodule

// File: rtl/tgt_cache_nextpc.sv
module tgt_cache_nextpc
  import tgt_cache_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            hit_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] tgt_i,
  output logic [PC_W-1:0] next_pc_o
);
  npc_src_e src;

  always_comb begin
    src = (hit_i && taken_i) ? NPC_TGT : NPC_SEQ;
    unique case (src)
      NPC_TGT: next_pc_o = tgt_i;
      default: next_pc_o = pc_i + PC_W'(SEQ_STEP);
    endcase
  end
endmodule

// File: rtl/tgt_cache.sv
module tgt_cache
  import tgt_cache_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            pred_taken_i,
  output logic            hit_o,
  output logic [PC_W-1:0] pred_tgt_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_tgt_i
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned TAG_W = PC_W - IDX_W - BYTE_OFF_W;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             hit;
  logic [PC_W-1:0]  tgt;

  tgt_cache_split #(.PC_W(PC_W), .OFF_W(BYTE_OFF_W), .IDX_W(IDX_W)) u_split_rd (
    .pc_i (fetch_pc_i),
    .idx_o(rd_idx),
    .tag_o(rd_tag)
  );

  tgt_cache_split #(.PC_W(PC_W), .OFF_W(BYTE_OFF_W), .IDX_W(IDX_W)) u_split_wr (
    .pc_i (upd_pc_i),
    .idx_o(wr_idx),
    .tag_o(wr_tag)
  );

  tgt_cache_store #(.PC_W(PC_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(rd_idx),
    .rd_tag_i(rd_tag),
    .hit_o   (hit),
    .rd_tgt_o(tgt),
    .wr_en_i (upd_en_i && upd_taken_i),
    .wr_idx_i(wr_idx),
    .wr_tag_i(wr_tag),
    .wr_tgt_i(upd_tgt_i)
  );

  tgt_cache_nextpc #(.PC_W(PC_W)) u_nextpc (
    .pc_i     (fetch_pc_i),
    .hit_i    (hit),
    .taken_i  (pred_taken_i),
    .tgt_i    (tgt),
    .next_pc_o(next_pc_o)
  );

  assign hit_o      = hit;
  assign pred_tgt_o = tgt;
endmodule

// File: rtl/tgt_cache_chk.sv
module tgt_cache_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_taken_i,
  input logic            hit_o,
  input logic [PC_W-1:0] pred_tgt_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            upd_en_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_tgt_i
);
  a_r5_miss_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == fetch_pc_i + PC_W'(4));

  a_r5_hit_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && pred_taken_i) |-> next_pc_o == pred_tgt_o);

  a_r5_hit_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pred_taken_i) |-> next_pc_o == fetch_pc_i + PC_W'(4));

  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> pred_tgt_o == '0);

  a_r6_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i) |=>
      (fetch_pc_i != $past(upd_pc_i) || (hit_o && pred_tgt_o == $past(upd_tgt_i))));
endmodule

bind tgt_cache tgt_cache_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_pc_i  (fetch_pc_i),
  .pred_taken_i(pred_taken_i),
  .hit_o       (hit_o),
  .pred_tgt_o  (pred_tgt_o),
  .next_pc_o   (next_pc_o),
  .upd_en_i    (upd_en_i),
  .upd_pc_i    (upd_pc_i),
  .upd_taken_i (upd_taken_i),
  .upd_tgt_i   (upd_tgt_i)
);

// File: tb/tgt_cache_test.sv
`timescale 1ns/1ps
module tgt_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken = 1'b0;
  logic        hit;
  logic [31:0] pred_tgt, next_pc;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_tgt = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural model: 16 entries, index = pc[5:2], tag = pc[31:6]
  bit          m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  always #2.5 clk = ~clk;

  tgt_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc), .pred_taken_i(pred_taken),
    .hit_o(hit), .pred_tgt_o(pred_tgt), .next_pc_o(next_pc),
    .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_tgt_i(upd_tgt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input bit pt, input bit ue,
                      input logic [31:0] upc, input bit ut, input logic [31:0] utgt,
                      input string req);
    int i;
    bit eh;
    logic [31:0] et, en;
    fetch_pc = pc; pred_taken = pt;
    upd_en = ue; upd_pc = upc; upd_taken = ut; upd_tgt = utgt;
    #1;
    i  = int'(pc[5:2]);
    eh = m_v[i] && (m_tag[i] == pc[31:6]);
    et = eh ? m_tgt[i] : 32'h0;
    en = (eh && pt) ? et : pc + 32'd4;
    chk(req, "hit", {31'b0, hit}, {31'b0, eh});
    chk(req, "pred_tgt", pred_tgt, et);
    chk(req, "next_pc", next_pc, en);
    @(posedge clk);
    if (ue && ut) begin
      i = int'(upc[5:2]);
      m_v[i] = 1'b1; m_tag[i] = upc[31:6]; m_tgt[i] = utgt;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input bit pt, input string req);
    step(pc, pt, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic wr(input logic [31:0] upc, input bit ut, input logic [31:0] utgt, input string req);
    step(32'h0000_0F00, 1'b0, 1'b1, upc, ut, utgt, req);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) m_v[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing hits after reset
    look(32'h0000_0000, 1'b1, "R1");
    look(32'h1234_5678, 1'b1, "R1");
    look(32'hFFFF_FFFC, 1'b1, "R1");   // R5 wrap to 0 as well

    // R8: write A while reading A -> old (miss), then hit
    step(32'h0000_1040, 1'b1, 1'b1, 32'h0000_1040, 1'b1, 32'h0000_2000, "R8");
    look(32'h0000_1040, 1'b1, "R8");
    // R4/R5: taken vs not taken on hit
    look(32'h0000_1040, 1'b0, "R5");
    look(32'h0000_1040, 1'b1, "R4");
    // R3: low bits ignored
    look(32'h0000_1043, 1'b1, "R3");
    look(32'h0000_1041, 1'b0, "R3");
    // R2: same index, different tag
    look(32'h0000_1080, 1'b1, "R2");
    look(32'h8000_1040, 1'b1, "R2");
    // R6: a different branch replaces the entry
    wr(32'h0000_1080, 1'b1, 32'h0000_3000, "R6");
    look(32'h0000_1080, 1'b1, "R6");
    look(32'h0000_1040, 1'b1, "R6");
    // R6: overwrite target of same branch
    wr(32'h0000_1080, 1'b1, 32'h0000_3100, "R6");
    look(32'h0000_1080, 1'b1, "R6");
    // R7: not-taken update leaves it alone
    wr(32'h0000_1080, 1'b0, 32'h0000_4444, "R7");
    look(32'h0000_1080, 1'b1, "R7");
    wr(32'h0000_20C0, 1'b0, 32'h0000_5555, "R7");
    look(32'h0000_20C0, 1'b1, "R7");
    // R9: fill all entries, check each independently
    for (int k = 0; k < 16; k++)
      wr(32'h0004_0000 + 32'(k*4), 1'b1, 32'h0009_0000 + 32'(k*16), "R9");
    for (int k = 0; k < 16; k++)
      look(32'h0004_0000 + 32'(k*4), 1'b1, "R9");
    wr(32'h0004_0014, 1'b1, 32'h00AB_CDE0, "R9");
    for (int k = 0; k < 16; k++)
      look(32'h0004_0000 + 32'(k*4), 1'b1, "R9");
    // R8 again with a different tag aliasing
    step(32'h0004_0008, 1'b1, 1'b1, 32'h0005_0008, 1'b1, 32'h0000_7770, "R8");
    look(32'h0004_0008, 1'b1, "R8");
    look(32'h0005_0008, 1'b1, "R8");
    // mixed traffic on a small address window
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      a = {22'h0, $urandom_range(0, 255), 2'($urandom)};
      b = {22'h0, $urandom_range(0, 255), 2'b00};
      step(a, 1'($urandom), 1'($urandom), b, 1'($urandom), $urandom, "R5");
    end
    // R1: reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) m_v[k] = 1'b0;
    @(negedge clk);
    look(32'h0004_0010, 1'b1, "R1");
    look(32'h0000_1080, 1'b1, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule